// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry-Out

This block prepares the second source operand of a 32-bit data-processing unit. It takes an operand word, a shift kind, a shift count and the current carry flag. It returns the shifted word together with the carry that the shift produces. The count is taken either from a 5-bit immediate field or from the low byte of a register value, so register counts run from 0 to 255. The block handles left shift, logical right shift, arithmetic right shift, rotate right, and a single-bit rotate right through the carry. Its results are registered one cycle after a valid request.

The shift kind is a 3-bit code: 0 shifts left (both the logical and the arithmetic left-shift mnemonics map here), 1 shifts right logically, 2 shifts right arithmetically, 3 rotates right, and 4 rotates right by one through the carry. Codes 5 to 7 are reserved. When `amt_from_reg` is 1, the count is the low 8 bits of `amt_reg`. When it is 0, the count is `amt_imm`, and an immediate of zero means 32 for the two right shifts. The carry-out is always the last bit that left the word. When nothing was shifted, the incoming carry is returned unchanged, so the flag keeps its value.

Top module: `operand_shifter`

## Requirements
- R1: Kind 0 with a count n from 1 to 31 gives operand shifted left by n with zeros entering, and carry-out equal to operand bit 32-n.
- R2: Kind 1 with a count n from 1 to 31 gives operand shifted right by n with zeros entering, and carry-out equal to operand bit n-1.
- R3: Kind 2 with a count n from 1 to 31 gives operand shifted right by n with copies of bit 31 entering, and carry-out equal to operand bit n-1.
- R4: Kind 3 rotates right by the count modulo 32, with carry-out equal to operand bit ((count-1) mod 32). A nonzero multiple of 32 returns the operand unchanged, with carry-out equal to bit 31.
- R5: Kind 4 ignores the count. It returns {carry_in, operand[31:1]}, with carry-out equal to operand bit 0.
- R6: With `amt_from_reg`=1, only `amt_reg[7:0]` sets the count. Bits 31 to 8 have no effect on the result or the carry.
- R7: With `amt_from_reg`=0, an immediate of 0 means a count of 32 for kinds 1 and 2, and a count of 0 for kinds 0 and 3. Other immediates are used as given.
- R8: A count of 0 on kinds 0 to 3 returns the operand unchanged, with carry-out equal to `carry_in`.
- R9: Kind 0 by exactly 32 gives zero with carry-out equal to bit 0. Kind 1 by exactly 32 gives zero with carry-out equal to bit 31. Either kind with a count above 32 gives zero with carry-out 0.
- R10: Kind 2 with a count of 32 or more fills every bit with operand bit 31, and carry-out equals operand bit 31.
- R11: `result`, `carry_out` and `out_valid` are registered. They reflect a request one clock after `in_valid`=1. `out_valid` follows `in_valid` with one cycle of delay. `result` and `carry_out` hold while `in_valid`=0. A synchronous reset clears all three to 0.
- R12: Reserved kinds 5 to 7 return the operand unchanged, with carry-out equal to `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| operand | input | 32 | Word to shift |
| shift_kind | input | 3 | Shift kind code (0 to 4 used) |
| amt_from_reg | input | 1 | 1: count from amt_reg low byte, 0: from amt_imm |
| amt_imm | input | 5 | Immediate count field |
| amt_reg | input | 32 | Register value supplying the count |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |
| out_valid | output | 1 | result and carry_out are from a request |

## Verification
The register-count path can trigger two behaviours in one request. Discarding the upper bits of the count register can leave a zero count, which must then pass the operand and the incoming carry through unchanged. The bench provokes this with a count register of 0x100 and a set carry, and expects the operand and the carry back exactly. A rotate by 64 combines the modulo reduction with the wrapped carry selection. It is judged by expecting the unchanged word and carry equal to bit 31, while `carry_in` is held at the opposite value.

// File: rtl/opshift_pkg.sv
package opshift_pkg;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  // Fill policy for the shared right-shift network
  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } fill_mode_e;

endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
  parameter int IMM_W = 5,
  parameter int CNT_W = 8,
  parameter int W     = 32
) (
  input  logic [2:0]       kind,
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic [CNT_W-1:0] reg_cnt,
  output logic [CNT_W-1:0] cnt
);
  import opshift_pkg::*;

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(W);

  logic imm_is_zero;
  logic right_kind;

  assign imm_is_zero = (imm == '0);
  assign right_kind  = (kind == SK_LSR) || (kind == SK_ASR);

  always_comb begin
    if (use_reg) begin
      cnt = reg_cnt;
    end else if (imm_is_zero && right_kind) begin
      cnt = FULL_CNT;
    end else begin
      cnt = CNT_W'(imm);
    end
  end

endmodule

// File: rtl/rshift_stages.sv
module rshift_stages #(
  parameter int W = 32
) (
  input  logic [W-1:0]         data_i,
  input  logic [$clog2(W)-1:0] amt,
  input  logic [1:0]           fill_mode,
  output logic [W-1:0]         data_o
);
  import opshift_pkg::*;

  localparam int SH_W = $clog2(W);

  logic [W-1:0] stage [SH_W+1];
  logic         sign_bit;

  assign stage[0] = data_i;
  assign sign_bit = data_i[W-1];

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [S-1:0] fill_k;
    always_comb begin
      case (fill_mode)
        FILL_SIGN: fill_k = {S{sign_bit}};
        FILL_WRAP: fill_k = stage[k][S-1:0];
        default:   fill_k = '0;
      endcase
    end
    assign stage[k+1] = amt[k] ? {fill_k, stage[k][W-1:S]} : stage[k];
  end

  assign data_o = stage[SH_W];

endmodule

// File: rtl/shifter_core.sv
module shifter_core #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic [2:0]       kind,
  input  logic [CNT_W-1:0] cnt,
  input  logic [W-1:0]     op,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cy
);
  import opshift_pkg::*;

  localparam int SH_W = $clog2(W);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(W);

  logic [W-1:0]    op_rev;
  logic [W-1:0]    net_in;
  logic [W-1:0]    net_out;
  logic [W-1:0]    net_rev;
  logic [1:0]      fill;
  logic [SH_W-1:0] low;
  logic [SH_W-1:0] idx_r;
  logic [SH_W-1:0] idx_l;
  logic            cnt_zero;
  logic            cnt_full;
  logic            cnt_above;
  logic            sign_bit;

  for (genvar b = 0; b < W; b++) begin : g_rev
    assign op_rev[b]  = op[W-1-b];
    assign net_rev[b] = net_out[W-1-b];
  end

  // A single right-shift network serves every kind; left shifts reverse around it
  assign net_in = (kind == SK_LSL) ? op_rev : op;
  assign low    = cnt[SH_W-1:0];

  always_comb begin
    case (kind)
      SK_ASR:  fill = FILL_SIGN;
      SK_ROR:  fill = FILL_WRAP;
      default: fill = FILL_ZERO;
    endcase
  end

  rshift_stages #(.W(W)) u_net (
    .data_i   (net_in),
    .amt      (low),
    .fill_mode(fill),
    .data_o   (net_out)
  );

  // Index of the last bit out; low==0 wraps to the width-boundary bit
  assign idx_r     = low - SH_W'(1);
  assign idx_l     = SH_W'(0) - low;
  assign cnt_zero  = (cnt == '0);
  assign cnt_full  = (cnt == FULL_CNT);
  assign cnt_above = (cnt > FULL_CNT);
  assign sign_bit  = op[W-1];

  always_comb begin
    res = op;
    cy  = cin;
    case (kind)
      SK_LSL: begin
        if (cnt_zero) begin
          res = op;
          cy  = cin;
        end else if (cnt_above) begin
          res = '0;
          cy  = 1'b0;
        end else begin
          res = cnt_full ? '0 : net_rev;
          cy  = op[idx_l];
        end
      end
      SK_LSR: begin
        if (cnt_zero) begin
          res = op;
          cy  = cin;
        end else if (cnt_above) begin
          res = '0;
          cy  = 1'b0;
        end else begin
          res = cnt_full ? '0 : net_out;
          cy  = op[idx_r];
        end
      end
      SK_ASR: begin
        if (cnt_zero) begin
          res = op;
          cy  = cin;
        end else if (cnt_full || cnt_above) begin
          res = {W{sign_bit}};
          cy  = sign_bit;
        end else begin
          res = net_out;
          cy  = op[idx_r];
        end
      end
      SK_ROR: begin
        if (cnt_zero) begin
          res = op;
          cy  = cin;
        end else begin
          res = net_out;
          cy  = op[idx_r];
        end
      end
      SK_RRX: begin
        res = {cin, op[W-1:1]};
        cy  = op[0];
      end
      default: begin
        res = op;
        cy  = cin;
      end
    endcase
  end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter int W     = 32,
  parameter int IMM_W = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     operand,
  input  logic [2:0]       shift_kind,
  input  logic             amt_from_reg,
  input  logic [IMM_W-1:0] amt_imm,
  input  logic [W-1:0]     amt_reg,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             carry_out,
  output logic             out_valid
);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     res_c;
  logic             cy_c;
  logic             unused_amt_hi;

  assign unused_amt_hi = ^amt_reg[W-1:CNT_W];

  shift_amt_sel #(.IMM_W(IMM_W), .CNT_W(CNT_W), .W(W)) u_amt (
    .kind   (shift_kind),
    .use_reg(amt_from_reg),
    .imm    (amt_imm),
    .reg_cnt(amt_reg[CNT_W-1:0]),
    .cnt    (cnt)
  );

  shifter_core #(.W(W), .CNT_W(CNT_W)) u_core (
    .kind(shift_kind),
    .cnt (cnt),
    .op  (operand),
    .cin (carry_in),
    .res (res_c),
    .cy  (cy_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_c;
        carry_out <= cy_c;
      end
    end
  end

endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 5,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [W-1:0]     operand,
  input logic [2:0]       shift_kind,
  input logic             amt_from_reg,
  input logic [IMM_W-1:0] amt_imm,
  input logic [W-1:0]     amt_reg,
  input logic             carry_in,
  input logic [W-1:0]     result,
  input logic             carry_out,
  input logic             out_valid
);

  logic armed;
  logic [CNT_W-1:0] rc;
  logic unused_imm;

  assign rc = amt_reg[CNT_W-1:0];
  assign unused_imm = ^amt_imm;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == $past(in_valid))); // R11

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(in_valid)) |-> ($stable(result) && $stable(carry_out))); // R11

  AST_RRX_FORM: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid && shift_kind == 3'd4)) |->
      (result == {$past(carry_in), $past(operand[W-1:1])} && carry_out == $past(operand[0]))); // R5

  AST_ZERO_CNT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid && amt_from_reg && rc == '0 && shift_kind < 3'd4)) |->
      (result == $past(operand) && carry_out == $past(carry_in))); // R8

  AST_LOGIC_BEYOND: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid && amt_from_reg && rc > CNT_W'(W) && shift_kind < 3'd2)) |->
      (result == '0 && !carry_out)); // R9

  AST_ASR_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid && amt_from_reg && rc >= CNT_W'(W) && shift_kind == 3'd2)) |->
      (result == {W{$past(operand[W-1])}} && carry_out == $past(operand[W-1]))); // R10

  AST_ROR_WHOLE_TURN: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid && amt_from_reg && rc != '0 && rc[$clog2(W)-1:0] == '0
                    && shift_kind == 3'd3)) |->
      (result == $past(operand) && carry_out == $past(operand[W-1]))); // R4

  AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid && shift_kind > 3'd4)) |->
      (result == $past(operand) && carry_out == $past(carry_in))); // R12

endmodule

bind operand_shifter operand_shifter_chk #(.W(W), .IMM_W(IMM_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .operand     (operand),
  .shift_kind  (shift_kind),
  .amt_from_reg(amt_from_reg),
  .amt_imm     (amt_imm),
  .amt_reg     (amt_reg),
  .carry_in    (carry_in),
  .result      (result),
  .carry_out   (carry_out),
  .out_valid   (out_valid)
);

// File: tb/operand_shifter_tb_top.sv
`timescale 1ns/1ps
module operand_shifter_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [2:0]  shift_kind = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  amt_imm = '0;
  logic [31:0] amt_reg = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;
  logic        out_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  operand_shifter dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .shift_kind(shift_kind), .amt_from_reg(amt_from_reg), .amt_imm(amt_imm),
    .amt_reg(amt_reg), .carry_in(carry_in), .result(result),
    .carry_out(carry_out), .out_valid(out_valid)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  kind;
    logic        src;
    logic [4:0]  imm;
    logic [31:0] rv;
    logic        cin;
    logic [31:0] op;
    logic [31:0] er;
    logic        ec;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  3'd0, 1'b0, 5'd4,  32'h0,        1'b0, 32'hF000000F, 32'h000000F0, 1'b1}, // R1
    '{4'd1,  3'd0, 1'b0, 5'd1,  32'h0,        1'b0, 32'h80000000, 32'h00000000, 1'b1}, // R1
    '{4'd2,  3'd1, 1'b0, 5'd1,  32'h0,        1'b0, 32'h00000003, 32'h00000001, 1'b1}, // R2
    '{4'd2,  3'd1, 1'b0, 5'd8,  32'h0,        1'b0, 32'h12345680, 32'h00123456, 1'b1}, // R2
    '{4'd3,  3'd2, 1'b0, 5'd4,  32'h0,        1'b1, 32'h80000010, 32'hF8000001, 1'b0}, // R3
    '{4'd3,  3'd2, 1'b0, 5'd1,  32'h0,        1'b0, 32'h40000001, 32'h20000000, 1'b1}, // R3
    '{4'd4,  3'd3, 1'b0, 5'd8,  32'h0,        1'b1, 32'h12345678, 32'h78123456, 1'b0}, // R4
    '{4'd4,  3'd3, 1'b1, 5'd0,  32'd36,       1'b0, 32'h0000000F, 32'hF0000000, 1'b1}, // R4
    '{4'd4,  3'd3, 1'b1, 5'd0,  32'd64,       1'b0, 32'h80000000, 32'h80000000, 1'b1}, // R4
    '{4'd5,  3'd4, 1'b0, 5'd7,  32'h0,        1'b1, 32'h00000003, 32'h80000001, 1'b1}, // R5
    '{4'd5,  3'd4, 1'b1, 5'd0,  32'd9,        1'b0, 32'h80000000, 32'h40000000, 1'b0}, // R5
    '{4'd6,  3'd1, 1'b1, 5'd0,  32'hFFFFFF04, 1'b1, 32'h000000F0, 32'h0000000F, 1'b0}, // R6
    '{4'd6,  3'd0, 1'b1, 5'd0,  32'h00000100, 1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1}, // R6 with R8
    '{4'd7,  3'd1, 1'b0, 5'd0,  32'h0,        1'b0, 32'h80000000, 32'h00000000, 1'b1}, // R7
    '{4'd7,  3'd2, 1'b0, 5'd0,  32'h0,        1'b0, 32'h80000000, 32'hFFFFFFFF, 1'b1}, // R7
    '{4'd7,  3'd0, 1'b0, 5'd0,  32'h0,        1'b0, 32'h12345678, 32'h12345678, 1'b0}, // R7
    '{4'd7,  3'd3, 1'b0, 5'd0,  32'h0,        1'b1, 32'h00000001, 32'h00000001, 1'b1}, // R7
    '{4'd9,  3'd0, 1'b1, 5'd0,  32'd32,       1'b0, 32'h00000001, 32'h00000000, 1'b1}, // R9
    '{4'd9,  3'd1, 1'b1, 5'd0,  32'd32,       1'b1, 32'h7FFFFFFF, 32'h00000000, 1'b0}, // R9
    '{4'd9,  3'd0, 1'b1, 5'd0,  32'd33,       1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R9
    '{4'd9,  3'd1, 1'b1, 5'd0,  32'd255,      1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R9
    '{4'd10, 3'd2, 1'b1, 5'd0,  32'd40,       1'b1, 32'h7FFFFFFF, 32'h00000000, 1'b0}, // R10
    '{4'd10, 3'd2, 1'b1, 5'd0,  32'd200,      1'b0, 32'h80000000, 32'hFFFFFFFF, 1'b1}, // R10
    '{4'd12, 3'd6, 1'b0, 5'd5,  32'h0,        1'b1, 32'h00000055, 32'h00000055, 1'b1}, // R12
    '{4'd8,  3'd2, 1'b1, 5'd0,  32'h0,        1'b0, 32'h80000000, 32'h80000000, 1'b0}  // R8
  };

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    operand      = v.op;
    shift_kind   = v.kind;
    amt_from_reg = v.src;
    amt_imm      = v.imm;
    amt_reg      = v.rv;
    carry_in     = v.cin;
    in_valid     = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check($sformatf("R%0d result", v.req), {1'b0, result}, {1'b0, v.er});
    check($sformatf("R%0d carry", v.req), {32'b0, carry_out}, {32'b0, v.ec});
    check("R11 out_valid after request", {32'b0, out_valid}, 33'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset result", {1'b0, result}, 33'd0);
    check("R11 reset carry/valid", {31'b0, carry_out, out_valid}, 33'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R11: outputs hold while idle although inputs change
    @(negedge clk);
    operand  = 32'hAAAA5555;
    carry_in = 1'b0;
    shift_kind = 3'd4;
    repeat (2) @(negedge clk);
    check("R11 hold result", {1'b0, result}, {1'b0, 32'h80000000});
    check("R11 hold carry", {32'b0, carry_out}, 33'd0);
    check("R11 idle out_valid", {32'b0, out_valid}, 33'd0);

    // R11: back-to-back requests, each seen one clock later
    @(negedge clk);
    operand = 32'h00000010; shift_kind = 3'd1; amt_from_reg = 1'b0; amt_imm = 5'd4;
    carry_in = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R11 first of pair", {carry_out, result}, {1'b0, 32'h00000001});
    operand = 32'h00000001; shift_kind = 3'd0; amt_imm = 5'd31;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second of pair R1", {carry_out, result}, {1'b0, 32'h80000000});

    // R11: synchronous reset clears outputs mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset mid-run", {carry_out, result}, 33'd0);
    check("R11 reset mid-run valid", {32'b0, out_valid}, 33'd0);
    rst = 1'b0;

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule